// File: doc/BRIEF.md
# Approximate Unsigned Multiplier with Recoded Partial Products

This block multiplies two unsigned operands and returns a product that is usually slightly below the exact value. It spends less adder logic than an exact array multiplier. Partial products are formed by an exact AND array. The final addition is also exact. The saving comes only from the reduction stage.

In every column that holds at least `MIN_TERMS` partial products, each mirrored pair of terms is recoded into two signals. The OR of the pair is the propagate term, which is 1 with probability 7/16 for random inputs. The AND of the pair is the generate term, which is 1 with probability 1/16. Because generate terms are rarely 1, all the generate terms of a column are merged by a single OR gate. Propagate terms are taken four at a time into a simplified 4-2 compressor that has no carry chain. All the bits that remain are reduced exactly to a sum row and a carry row, and a vector-merge adder adds those two rows.

The block suits error-tolerant datapaths such as pixel filters. A parameter selects whether the product is registered, with one cycle of latency, or driven combinationally.

Top module: `approx_pp_mult`

## Requirements
- R1: If either operand is zero, the product is exactly zero.
- R2: If one operand equals 1, the product equals the other operand, zero-extended to 16 bits.
- R3: The product never exceeds the exact product a*b. The approximation can only remove value.
- R4: For the default 8-bit width, the exact product minus the output is at most 5464. The bound is reached at 255 x 255, where the output is 59561.
- R5: The product is symmetric: f(a,b) equals f(b,a) for every operand pair.
- R6: Recoding applies to every column that holds four or more terms (weights 2^3 to 2^11 at 8 bits).
  - For each mirrored pair a[m]&b[n] and a[n]&b[m] in such a column, the propagate term (OR) and the generate term (AND) are formed.
  - All generate terms of the column are ORed into one bit of that column's weight.
  - A diagonal term a[k]&b[k] passes through unchanged.
  - Example: 15 x 15 gives 217.
- R7: In a recoded column, propagate terms are taken in groups of four (x1..x4, in order of the smaller index m) into an approximate compressor.
  - Its sum output, (x1^x2)|(x3^x4), has the column's weight.
  - Its carry output, (x1&x2)|(x3&x4), has the next column's weight.
  - At 8 bits, only the weight-2^7 column has four propagate terms.
- R8: Columns with fewer than four terms, and all bits left after recoding, are summed exactly. If both operands are below 4, or both are multiples of 64, the product is exact.
- R9: With `REG_OUT`=1, the output is registered.
  - It shows the result for the operands present at a rising edge after that edge, one cycle of latency.
  - An active-high synchronous reset clears the output to zero.
  - With `REG_OUT`=0, the output follows the operands within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_in | input | OP_W | First unsigned operand |
| b_in | input | OP_W | Second unsigned operand |
| prod | output | 2*OP_W | Approximate unsigned product |

## Verification
The bench builds the block twice at `OP_W`=8, `MIN_TERMS`=4 and `USE_CMP`=1. One copy has `REG_OUT`=1 and the other has `REG_OUT`=0, so both output variants and the one-cycle latency are covered. At 8 bits the whole operand space is small enough to sweep completely. The sweep compares every pair against a column-by-column model of the recoding and checks the exact worst-case shortfall of 5464. A seeded random pass biased toward zero, one, all-ones and corner-aligned operands then checks symmetry by swapping operands, and checks a reset asserted mid-stream.

// File: rtl/apm_pkg.sv
package apm_pkg;

   // lowest row index m that contributes to column c of an n x n array
   function automatic int col_lo(input int n, input int c);
      return (c > n - 1) ? c - (n - 1) : 0;
   endfunction

   // number of partial products that land in column c
   function automatic int col_terms(input int n, input int c);
      int hi;
      hi = (c < n - 1) ? c : n - 1;
      return hi - col_lo(n, c) + 1;
   endfunction

   // width of the compressor carry bundle passed between neighbouring columns
   function automatic int carry_width(input int n);
      return (n / 8 > 0) ? n / 8 : 1;
   endfunction

   // slots per column after recoding (also the number of rows fed to the merge)
   function automatic int slot_rows(input int n);
      return n + 2 * carry_width(n);
   endfunction

endpackage

// File: rtl/apm_ppgen.sv
module apm_ppgen #(
   parameter int N = 8
) (
   input  logic [N-1:0]   a,
   input  logic [N-1:0]   b,
   output logic [N*N-1:0] pp
);
   // pp[m*N+n] = a[m] & b[n]
   for (genvar m = 0; m < N; m++) begin : g_row
      for (genvar n = 0; n < N; n++) begin : g_bit
         assign pp[m*N + n] = a[m] & b[n];
      end
   end
endmodule

// File: rtl/apm_cmp42.sv
module apm_cmp42 (
   input  logic [3:0] x,
   output logic       sum,
   output logic       carry
);
   assign sum   = (x[0] ^ x[1]) | (x[2] ^ x[3]);
   assign carry = (x[0] & x[1]) | (x[2] & x[3]);
endmodule

// File: rtl/apm_column.sv
module apm_column #(
   parameter int N         = 8,
   parameter int COL       = 0,
   parameter int MIN_TERMS = 4,
   parameter bit USE_CMP   = 1'b1
) (
   input  logic [apm_pkg::col_terms(N, COL)-1:0] terms,
   input  logic [apm_pkg::carry_width(N)-1:0]    cin,
   output logic [apm_pkg::slot_rows(N)-1:0]      slots,
   output logic [apm_pkg::carry_width(N)-1:0]    cout
);
   localparam int NT       = apm_pkg::col_terms(N, COL);
   localparam int CW       = apm_pkg::carry_width(N);
   localparam bit RECODE   = (NT >= MIN_TERMS);
   localparam int NPAIR    = NT / 2;
   localparam bit HAS_DIAG = (NT % 2) == 1;
   localparam int NCMP     = (RECODE && USE_CMP) ? NPAIR / 4 : 0;
   localparam int NREST    = NPAIR - 4 * NCMP;

   if (!RECODE) begin : g_exact
      always_comb begin
         slots          = '0;
         slots[NT-1:0]  = terms;
         slots[NT +: CW] = cin;
      end
      assign cout = '0;
   end else begin : g_recode
      logic [NPAIR-1:0] prop;
      logic [NPAIR-1:0] gen;
      logic [CW-1:0]    cs_sum;
      logic [CW-1:0]    cs_cy;

      // terms k and NT-1-k are the mirrored pair a[m]b[n] / a[n]b[m]
      for (genvar k = 0; k < NPAIR; k++) begin : g_pair
         assign prop[k] = terms[k] | terms[NT-1-k];
         assign gen[k]  = terms[k] & terms[NT-1-k];
      end

      for (genvar j = 0; j < CW; j++) begin : g_cmp
         if (j < NCMP) begin : g_on
            apm_cmp42 u_cmp (
               .x     (prop[4*j +: 4]),
               .sum   (cs_sum[j]),
               .carry (cs_cy[j])
            );
         end else begin : g_off
            assign cs_sum[j] = 1'b0;
            assign cs_cy[j]  = 1'b0;
         end
      end

      always_comb begin
         slots    = '0;
         slots[0] = |gen;
         for (int i = 0; i < NREST; i++) slots[1+i] = prop[4*NCMP + i];
         if (HAS_DIAG) slots[1+NREST] = terms[NPAIR];
         slots[2+NREST +: CW]      = cin;
         slots[2+NREST+CW +: CW]   = cs_sum;
      end
      assign cout = cs_cy;
   end
endmodule

// File: rtl/apm_merge.sv
module apm_merge #(
   parameter int W    = 16,
   parameter int ROWS = 10
) (
   input  logic [ROWS-1:0][W-1:0] rows,
   output logic [W-1:0]           total
);
   logic [W-1:0] s_acc [ROWS-1];
   logic [W-1:0] c_acc [ROWS-1];

   assign s_acc[0] = rows[0];
   assign c_acc[0] = rows[1];

   // exact carry-save chain: one row of full adders per extra input row
   for (genvar i = 1; i < ROWS - 1; i++) begin : g_csa
      logic [W-1:0] r;
      logic [W-1:0] mj;
      assign r        = rows[i+1];
      assign s_acc[i] = s_acc[i-1] ^ c_acc[i-1] ^ r;
      assign mj       = (s_acc[i-1] & c_acc[i-1]) | (s_acc[i-1] & r) | (c_acc[i-1] & r);
      assign c_acc[i] = mj << 1;
   end

   // vector-merge addition of the final sum and carry rows
   assign total = s_acc[ROWS-2] + c_acc[ROWS-2];
endmodule

// File: rtl/approx_pp_mult.sv
module approx_pp_mult #(
   parameter int OP_W      = 8,
   parameter int MIN_TERMS = 4,
   parameter bit USE_CMP   = 1'b1,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [OP_W-1:0]   a_in,
   input  logic [OP_W-1:0]   b_in,
   output logic [2*OP_W-1:0] prod
);
   localparam int PW   = 2 * OP_W;
   localparam int NCOL = PW - 1;
   localparam int CW   = apm_pkg::carry_width(OP_W);
   localparam int ROWS = apm_pkg::slot_rows(OP_W);

   if (OP_W < 4) begin : g_bad_width
      $error("approx_pp_mult: OP_W must be at least 4");
   end
   if (MIN_TERMS < 2) begin : g_bad_terms
      $error("approx_pp_mult: MIN_TERMS must be at least 2");
   end

   logic [OP_W*OP_W-1:0]    pp;
   logic [CW-1:0]           col_cy [PW];
   logic [ROWS-1:0]         col_slots [NCOL];
   logic [ROWS-1:0][PW-1:0] rows;
   logic [PW-1:0]           sum_w;

   apm_ppgen #(.N(OP_W)) u_ppgen (
      .a  (a_in),
      .b  (b_in),
      .pp (pp)
   );

   assign col_cy[0] = '0;

   for (genvar c = 0; c < NCOL; c++) begin : g_col
      localparam int NT = apm_pkg::col_terms(OP_W, c);
      localparam int LO = apm_pkg::col_lo(OP_W, c);
      logic [NT-1:0] t;
      for (genvar k = 0; k < NT; k++) begin : g_term
         assign t[k] = pp[(LO + k) * OP_W + (c - LO - k)];
      end
      apm_column #(
         .N         (OP_W),
         .COL       (c),
         .MIN_TERMS (MIN_TERMS),
         .USE_CMP   (USE_CMP)
      ) u_col (
         .terms (t),
         .cin   (col_cy[c]),
         .slots (col_slots[c]),
         .cout  (col_cy[c+1])
      );
   end

   // transpose column slots into rows for the exact reduction
   always_comb begin
      rows = '0;
      for (int r = 0; r < ROWS; r++) begin
         for (int c = 0; c < NCOL; c++) rows[r][c] = col_slots[c][r];
      end
      for (int r = 0; r < CW; r++) rows[r][PW-1] = col_cy[PW-1][r];
   end

   apm_merge #(.W(PW), .ROWS(ROWS)) u_merge (
      .rows  (rows),
      .total (sum_w)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) prod <= '0;
         else     prod <= sum_w;
      end

      logic [PW-1:0] exact_w;
      assign exact_w = PW'(a_in) * PW'(b_in);

      // R9
      rst_clear_chk: assert property (@(posedge clk) rst |=> prod == '0);
      // R1
      zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
         (a_in == '0 || b_in == '0) |=> prod == '0);
      // R2
      unit_operand_chk: assert property (@(posedge clk) disable iff (rst)
         (a_in == OP_W'(1)) |=> prod == PW'($past(b_in)));
      // R3
      no_overshoot_chk: assert property (@(posedge clk) disable iff (rst)
         !rst |=> prod <= $past(exact_w));
   end else begin : g_comb
      assign prod = sum_w;
   end
endmodule

// File: tb/approx_pp_mult_bench.sv
module approx_pp_mult_bench;
   localparam int W         = 8;
   localparam int PW        = 16;
   localparam int ERR_BOUND = 5464;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [W-1:0]  a_drv = '0;
   logic [W-1:0]  b_drv = '0;
   logic [PW-1:0] prod_reg;
   logic [PW-1:0] prod_comb;
   int            checks = 0;
   int            errors = 0;
   bit            done = 1'b0;
   int unsigned   prev_exp = 0;

   always #5 clk = ~clk;

   approx_pp_mult #(.OP_W(W), .REG_OUT(1'b1)) u_approx_pp_mult (
      .clk (clk), .rst (rst), .a_in (a_drv), .b_in (b_drv), .prod (prod_reg)
   );
   approx_pp_mult #(.OP_W(W), .REG_OUT(1'b0)) u_approx_pp_mult_comb (
      .clk (clk), .rst (rst), .a_in (a_drv), .b_in (b_drv), .prod (prod_comb)
   );

   function automatic int unsigned bitv(input int unsigned v, input int i);
      return (v >> i) & 1;
   endfunction

   // column-by-column model of the recoding described in R6, R7 and R8
   function automatic int unsigned model(input int unsigned a, input int unsigned b);
      int unsigned acc;
      acc = 0;
      for (int c = 0; c <= 2*W-2; c++) begin
         int lo, hi, nt, np, ncmp;
         int unsigned gor;
         int unsigned pv [0:15];
         lo = (c > W-1) ? c-(W-1) : 0;
         hi = (c < W-1) ? c : W-1;
         nt = hi - lo + 1;
         if (nt < 4) begin
            for (int m = lo; m <= hi; m++) acc += (bitv(a, m) & bitv(b, c-m)) << c;
         end else begin
            np  = nt / 2;
            gor = 0;
            for (int k = 0; k < np; k++) begin
               int m, n;
               int unsigned x, y;
               m = lo + k;
               n = c - m;
               x = bitv(a, m) & bitv(b, n);
               y = bitv(a, n) & bitv(b, m);
               pv[k] = x | y;
               gor   = gor | (x & y);
            end
            acc += gor << c;
            ncmp = np / 4;
            for (int j = 0; j < ncmp; j++) begin
               int unsigned s, cy;
               s  = (pv[4*j] ^ pv[4*j+1]) | (pv[4*j+2] ^ pv[4*j+3]);
               cy = (pv[4*j] & pv[4*j+1]) | (pv[4*j+2] & pv[4*j+3]);
               acc += (s << c) + (cy << (c+1));
            end
            for (int r = 4*ncmp; r < np; r++) acc += pv[r] << c;
            if (nt % 2 == 1) acc += (bitv(a, c/2) & bitv(b, c/2)) << c;
         end
      end
      return acc;
   endfunction

   task automatic chk_eq(input string req, input int unsigned act, input int unsigned exp_v);
      checks++;
      if (act != exp_v) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   task automatic chk_le(input string req, input int unsigned act, input int unsigned lim);
      checks++;
      if (act > lim) begin
         errors++;
         $display("FAIL %s: actual=%0d expected<=%0d", req, act, lim);
      end
   endtask

   // drive at negedge, check comb output, then the registered output after the edge
   task automatic apply(input int unsigned a, input int unsigned b, output int unsigned got);
      int unsigned e, x;
      @(negedge clk);
      a_drv = W'(a);
      b_drv = W'(b);
      #1;
      e = model(a, b);
      x = a * b;
      got = prod_comb;
      chk_eq("R6 R7 model match", prod_comb, e);
      chk_le("R3 no overshoot", prod_comb, x);
      chk_le("R4 error bound", x - ((prod_comb <= x) ? prod_comb : x), ERR_BOUND);
      if (a == 0 || b == 0) chk_eq("R1 zero operand", prod_comb, 0);
      if (a == 1) chk_eq("R2 unit operand a", prod_comb, b);
      if (b == 1) chk_eq("R2 unit operand b", prod_comb, a);
      if ((a < 4 && b < 4) || (a % 64 == 0 && b % 64 == 0)) chk_eq("R8 exact region", prod_comb, x);
      chk_eq("R9 register holds before edge", prod_reg, prev_exp);
      @(posedge clk);
      #1;
      chk_eq("R9 registered result", prod_reg, e);
      prev_exp = e;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R9 watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int unsigned r1, r2;
      void'($urandom(32'd20240611));
      a_drv = 8'd77;
      b_drv = 8'd99;
      repeat (3) @(posedge clk);
      #1;
      chk_eq("R9 reset state", prod_reg, 0);
      @(negedge clk);
      a_drv = '0;
      b_drv = '0;
      rst = 1'b0;

      // directed corners
      apply(255, 255, r1);
      chk_eq("R4 R7 worst case 255x255", r1, 59561);
      apply(15, 15, r1);
      chk_eq("R6 generate merge 15x15", r1, 217);
      apply(1, 200, r1);
      chk_eq("R2 one times 200", r1, 200);
      apply(0, 255, r1);
      chk_eq("R1 zero times 255", r1, 0);
      apply(192, 192, r1);
      chk_eq("R8 top bits exact", r1, 36864);

      // full sweep
      for (int a = 0; a < 256; a++) begin
         for (int b = 0; b < 256; b++) begin
            apply(a, b, r1);
         end
      end

      // seeded random, biased to corners; R5 symmetry by swapping
      for (int i = 0; i < 1500; i++) begin
         int unsigned a, b, kind;
         kind = $urandom % 4;
         case (kind)
            0: begin a = $urandom % 256; b = $urandom % 256; end
            1: begin a = $urandom % 4;   b = $urandom % 256; end
            2: begin
               a = (($urandom % 2) == 0) ? 255 : 1;
               b = $urandom % 256;
            end
            default: begin a = ($urandom % 4) * 64; b = ($urandom % 4) * 64; end
         endcase
         apply(a, b, r1);
         apply(b, a, r2);
         chk_eq("R5 symmetry", r2, r1);
      end

      // reset asserted mid-stream
      @(negedge clk);
      a_drv = 8'd255;
      b_drv = 8'd255;
      rst = 1'b1;
      @(posedge clk);
      #1;
      chk_eq("R9 mid-run reset clears", prod_reg, 0);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk);
      #1;
      chk_eq("R9 resumes after reset", prod_reg, 59561);
      prev_exp = 59561;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule